// File: doc/BRIEF.md
# Multiplex Scan Timer

This block produces every display timing signal for an eight-character dot-matrix module from a single display timebase. The timebase is either a local free-running square wave or a clock arriving from a neighbouring module. A select input chooses between them, so that a chain of modules can run from one shared clock and blink in step. All logic runs on one fast system clock. The display timebase only acts as a count enable, taken from the local square wave or from the synchronized rising edges of the external input.

Each display clock tick advances a 32-step phase counter. The phase value goes to a brightness modulator, and its wrap marks a slot. Seven slots make one multiplex step, so one step lasts 224 display clocks. Each step moves the row scan to the next of five rows, and the scan alternates between two row banks after every fifth row. A further counter over 128 steps makes the blink wave: it is low for 64 steps and high for 64 steps. Reset returns every counter to zero, which keeps cascaded modules aligned.

Top module: `mux_scan_timer`

## Requirements
- R1: While reset is held and directly after it, phase, slot index, row index, row bank, blink, both strobes and the local clock output are all 0.
- R2: With clk_sel = 1 the counters advance once per rising edge of the local square wave. clk_oe is 1, and clk_out toggles every OSC_HALF system cycles.
- R3: With clk_sel = 0 clk_oe is 0, and the counters advance once per rising edge of ext_clk, detected after a two-stage synchronizer.
- R4: phase increases by one per display clock, from 0 up to 31, and then wraps to 0. slot_strobe is high for exactly one cycle each time phase wraps, so it fires once per 32 display clocks.
- R5: slot_idx counts slots from 0 to 6 and then wraps. mux_strobe is high for one cycle, together with slot_strobe, when slot_idx wraps to 0, so it fires once per 224 display clocks.
- R6: row_idx advances by one per multiplex step through 0 to 4 and then wraps. row_bank (0 or 1) flips exactly when row_idx wraps from 4 to 0. After k steps from reset, row_idx = k mod 5 and row_bank = (k div 5) mod 2.
- R7: blink is 0 after reset. It rises after 64 multiplex steps (64·224 display clocks), and then repeats with a period of 128 steps (224·128 display clocks).
- R8: Two instances reset together and fed the same display clock produce identical outputs on every cycle.
- R9: With clk_sel = 1, activity on ext_clk has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_sel | input | 1 | 1: local timebase, driven out; 0: timebase taken from ext_clk |
| ext_clk | input | 1 | Display clock from another module (asynchronous) |
| clk_out | output | 1 | Local square-wave display clock |
| clk_oe | output | 1 | Drive enable for clk_out onto the shared clock line |
| phase | output | PW | Position inside the current slot, 0..PRE_DIV-1 |
| slot_idx | output | SW | Slot number inside the multiplex step, 0..SLOTS-1 |
| slot_strobe | output | 1 | One-cycle pulse at every slot boundary |
| mux_strobe | output | 1 | One-cycle pulse at every multiplex step |
| row_idx | output | RW | Active row within the bank, 0..ROWS-1 |
| row_bank | output | 1 | Active row bank |
| blink | output | 1 | Blink/flash level |

## Verification
The assertions rely on two display clock ticks never arriving on adjacent system cycles. They also rely on clk_sel staying constant between resets, and on ext_clk being low when reset is released. The stimulus meets these conditions: the external clock is driven with high and low phases of at least two system cycles each, clk_sel is changed only while reset is held, and ext_clk is parked low at every reset. The local timebase in the bench toggles every system cycle, which is the fastest rate that still leaves a gap between ticks.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic {
    SRC_EXT = 1'b0,
    SRC_INT = 1'b1
  } tick_src_e;
endpackage

// File: rtl/scan_osc.sv
module scan_osc #(
  parameter int OSC_HALF = 4,
  localparam int OW = $clog2(OSC_HALF + 1)
) (
  input  logic clk,
  input  logic rst_n,
  output logic osc_level,
  output logic osc_rise
);
  logic [OW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;
  logic          wrap;

  always_comb begin
    wrap     = (cnt_q == OW'(OSC_HALF - 1));
    cnt_d    = wrap ? '0 : cnt_q + 1'b1;
    lvl_d    = wrap ? ~lvl_q : lvl_q;
    osc_rise = wrap && !lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign osc_level = lvl_q;

  // R2
  osc_rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_rise |=> (!osc_rise && osc_level));
endmodule

// File: rtl/scan_src_sel.sv
module scan_src_sel
  import scan_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  tick_src_e src,
  input  logic      osc_rise,
  input  logic      ext_clk,
  output logic      dclk_en
);
  logic s1_q, s2_q, s3_q;
  logic ext_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= ext_clk;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_comb begin
    ext_rise = s2_q && !s3_q;
    dclk_en  = (src == SRC_INT) ? osc_rise : ext_rise;
  end

  // R3
  ext_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_EXT && dclk_en) |-> ($past(ext_clk, 2) && !$past(ext_clk, 3)));
endmodule

// File: rtl/scan_counter.sv
module scan_counter #(
  parameter int PRE_DIV = 32,
  parameter int SLOTS   = 7,
  parameter int ROWS    = 5,
  localparam int PW = $clog2(PRE_DIV),
  localparam int SW = $clog2(SLOTS),
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dclk_en,
  output logic [PW-1:0] phase,
  output logic [SW-1:0] slot_idx,
  output logic          slot_stb,
  output logic          mux_stb,
  output logic [RW-1:0] row_idx,
  output logic          row_bank
);
  logic [PW-1:0] phase_q, phase_d;
  logic [SW-1:0] slot_q, slot_d;
  logic [RW-1:0] row_q, row_d;
  logic          bank_q, bank_d;
  logic          sstb_q, mstb_q;
  logic          slot_tc, mux_tc, row_last;

  always_comb begin
    slot_tc  = dclk_en && (phase_q == PW'(PRE_DIV - 1));
    mux_tc   = slot_tc && (slot_q == SW'(SLOTS - 1));
    row_last = (row_q == RW'(ROWS - 1));

    phase_d = phase_q;
    if (dclk_en) phase_d = slot_tc ? '0 : phase_q + 1'b1;

    slot_d = slot_q;
    if (slot_tc) slot_d = mux_tc ? '0 : slot_q + 1'b1;

    row_d  = row_q;
    bank_d = bank_q;
    if (mux_tc) begin
      row_d = row_last ? '0 : row_q + 1'b1;
      if (row_last) bank_d = ~bank_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      slot_q  <= '0;
      row_q   <= '0;
      bank_q  <= 1'b0;
      sstb_q  <= 1'b0;
      mstb_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      slot_q  <= slot_d;
      row_q   <= row_d;
      bank_q  <= bank_d;
      sstb_q  <= slot_tc;
      mstb_q  <= mux_tc;
    end
  end

  assign phase    = phase_q;
  assign slot_idx = slot_q;
  assign slot_stb = sstb_q;
  assign mux_stb  = mstb_q;
  assign row_idx  = row_q;
  assign row_bank = bank_q;

  // R4
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dclk_en |=> !dclk_en);
  // R4
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dclk_en && phase_q == PW'(PRE_DIV - 1)) |=> (phase_q == '0 && sstb_q));
  // R4
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dclk_en |=> ($stable(phase_q) && !sstb_q));
  // R5
  mux_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mstb_q |-> (sstb_q && slot_q == '0));
  // R6
  row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_q < RW'(ROWS));
  // R6
  bank_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bank_q) || $fell(bank_q)) |-> (mstb_q && $past(row_q) == RW'(ROWS - 1)));
endmodule

// File: rtl/scan_blink.sv
module scan_blink #(
  parameter int BLINK_DIV = 128,
  localparam int BW = $clog2(BLINK_DIV)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic blink
);
  logic [BW-1:0] cnt_q, cnt_d;
  logic          blink_q, blink_d;

  always_comb begin
    cnt_d = cnt_q;
    if (step) cnt_d = (cnt_q == BW'(BLINK_DIV - 1)) ? '0 : cnt_q + 1'b1;
    blink_d = (cnt_d >= BW'(BLINK_DIV / 2));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      blink_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      blink_q <= blink_d;
    end
  end

  assign blink = blink_q;

  // R7
  blink_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(blink_q) || $fell(blink_q)) |-> $past(step));
endmodule

// File: rtl/mux_scan_timer.sv
module mux_scan_timer
  import scan_pkg::*;
#(
  parameter int OSC_HALF  = 4,
  parameter int PRE_DIV   = 32,
  parameter int SLOTS     = 7,
  parameter int ROWS      = 5,
  parameter int BLINK_DIV = 128,
  localparam int PW = $clog2(PRE_DIV),
  localparam int SW = $clog2(SLOTS),
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_sel,
  input  logic          ext_clk,
  output logic          clk_out,
  output logic          clk_oe,
  output logic [PW-1:0] phase,
  output logic [SW-1:0] slot_idx,
  output logic          slot_strobe,
  output logic          mux_strobe,
  output logic [RW-1:0] row_idx,
  output logic          row_bank,
  output logic          blink
);
  logic      rs1_q, rs2_q;
  logic      osc_rise, dclk_en;
  tick_src_e src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  assign src    = tick_src_e'(clk_sel);
  assign clk_oe = clk_sel;

  scan_osc #(.OSC_HALF(OSC_HALF)) osc_i (
    .clk(clk), .rst_n(rs2_q), .osc_level(clk_out), .osc_rise(osc_rise)
  );

  scan_src_sel src_i (
    .clk(clk), .rst_n(rs2_q), .src(src), .osc_rise(osc_rise),
    .ext_clk(ext_clk), .dclk_en(dclk_en)
  );

  scan_counter #(.PRE_DIV(PRE_DIV), .SLOTS(SLOTS), .ROWS(ROWS)) cnt_i (
    .clk(clk), .rst_n(rs2_q), .dclk_en(dclk_en), .phase(phase),
    .slot_idx(slot_idx), .slot_stb(slot_strobe), .mux_stb(mux_strobe),
    .row_idx(row_idx), .row_bank(row_bank)
  );

  scan_blink #(.BLINK_DIV(BLINK_DIV)) blink_i (
    .clk(clk), .rst_n(rs2_q), .step(mux_strobe), .blink(blink)
  );
endmodule

// File: tb/mux_scan_timer_tb_top.sv
`timescale 1ns/1ps
module mux_scan_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_sel = 1'b1;
  logic ext = 1'b0;
  logic share = 1'b0;
  logic peer_ext;

  logic       clk_out, clk_oe, slot_strobe, mux_strobe, row_bank, blink;
  logic [4:0] phase;
  logic [2:0] slot_idx, row_idx;
  logic       p_clk_out, p_clk_oe, p_slot_strobe, p_mux_strobe, p_row_bank, p_blink;
  logic [4:0] p_phase;
  logic [2:0] p_slot_idx, p_row_idx;

  always #2.5 clk = ~clk;
  assign peer_ext = share ? ext : 1'b0;

  mux_scan_timer #(.OSC_HALF(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_clk(ext),
    .clk_out(clk_out), .clk_oe(clk_oe), .phase(phase), .slot_idx(slot_idx),
    .slot_strobe(slot_strobe), .mux_strobe(mux_strobe), .row_idx(row_idx),
    .row_bank(row_bank), .blink(blink)
  );

  mux_scan_timer #(.OSC_HALF(1)) peer_i (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_clk(peer_ext),
    .clk_out(p_clk_out), .clk_oe(p_clk_oe), .phase(p_phase), .slot_idx(p_slot_idx),
    .slot_strobe(p_slot_strobe), .mux_strobe(p_mux_strobe), .row_idx(p_row_idx),
    .row_bank(p_row_bank), .blink(p_blink)
  );

  int checks = 0;
  int fails = 0;
  logic timeout = 1'b0;

  // monitor state
  int edge_cnt, slot_seen, mux_seen, blink_rises;
  int last_slot, slot_gap, last_mux, mux_gap, last_blink, blink_gap, first_blink;
  int lock_err;
  logic src_prev, blink_prev;
  int row_log [16];
  int bank_log [16];

  always @(negedge clk) begin
    logic src_now;
    src_now = clk_sel ? clk_out : ext;
    if (src_now && !src_prev) edge_cnt++;
    src_prev = src_now;
    if (slot_strobe) begin
      slot_gap = edge_cnt - last_slot;
      last_slot = edge_cnt;
      slot_seen++;
    end
    if (mux_strobe) begin
      mux_gap = edge_cnt - last_mux;
      last_mux = edge_cnt;
      mux_seen++;
      if (mux_seen < 16) begin
        row_log[mux_seen] = row_idx;
        bank_log[mux_seen] = row_bank;
      end
    end
    if (blink && !blink_prev) begin
      if (blink_rises == 0) first_blink = edge_cnt;
      blink_gap = edge_cnt - last_blink;
      last_blink = edge_cnt;
      blink_rises++;
    end
    blink_prev = blink;
    if ({phase, slot_idx, slot_strobe, mux_strobe, row_idx, row_bank, blink, clk_out} !==
        {p_phase, p_slot_idx, p_slot_strobe, p_mux_strobe, p_row_idx, p_row_bank, p_blink, p_clk_out})
      lock_err++;
  end

  initial begin
    repeat (190000) @(posedge clk);
    timeout = 1'b1;
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    edge_cnt = 0; slot_seen = 0; mux_seen = 0; blink_rises = 0;
    last_slot = 0; slot_gap = 0; last_mux = 0; mux_gap = 0;
    last_blink = 0; blink_gap = 0; first_blink = 0; lock_err = 0;
    src_prev = 1'b0; blink_prev = 1'b0;
  endtask

  task automatic do_reset(input logic sel, input logic shr);
    rst_n = 1'b0;
    ext = 1'b0;
    clk_sel = sel;
    share = shr;
    repeat (3) tick();
    clear_mon();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  // one display period: internal mode ticks (ext toggles, must be ignored)
  task automatic advance(input int half);
    if (clk_sel) begin
      ext = ~ext;
      tick();
    end else begin
      ext = 1'b1;
      repeat (half) tick();
      ext = 1'b0;
      repeat (half) tick();
    end
  endtask

  // vector table: sel, ext half period, kind (0 slot, 1 mux), expected gap
  localparam int NV = 5;
  localparam int VT [NV][4] = '{
    '{1, 0, 0, 32},
    '{1, 0, 1, 224},
    '{0, 2, 0, 32},
    '{0, 2, 1, 224},
    '{0, 3, 1, 224}
  };

  initial begin
    int e0;
    clear_mon();

    // R1 reset state
    repeat (3) tick();
    @(negedge clk);
    check({phase, slot_idx, row_idx, row_bank, blink, slot_strobe, mux_strobe, clk_out} == '0,
          "R1", {phase, slot_idx, row_idx}, 0);

    // table walk: R4 slot gap, R5 multiplex gap, R2/R3 modes, R8 lockstep
    for (int i = 0; i < NV; i++) begin
      do_reset(VT[i][0][0], 1'b1);
      while (((VT[i][2] == 0) ? slot_seen : mux_seen) < 3 && !timeout) advance(VT[i][1]);
      if (VT[i][2] == 0)
        check(slot_gap == VT[i][3], "R4", slot_gap, VT[i][3]);
      else
        check(mux_gap == VT[i][3], "R5", mux_gap, VT[i][3]);
      check(clk_oe == VT[i][0][0], VT[i][0] != 0 ? "R2" : "R3", clk_oe, VT[i][0]);
      check(lock_err == 0, "R8", lock_err, 0);
    end

    // R2 local clock toggles every system cycle (OSC_HALF = 1)
    do_reset(1'b1, 1'b0);
    e0 = edge_cnt;
    repeat (20) tick();
    check(edge_cnt - e0 == 10, "R2", edge_cnt - e0, 10);

    // R3 / R4 external edges counted after synchronizer
    do_reset(1'b0, 1'b1);
    repeat (5) advance(2);
    repeat (4) tick();
    @(negedge clk);
    check(phase == 5 && slot_idx == 0, "R4", phase, 5);
    repeat (27) advance(2);
    repeat (4) tick();
    @(negedge clk);
    check(phase == 0 && slot_idx == 1, "R5", slot_idx, 1);
    check(clk_oe == 1'b0, "R3", clk_oe, 0);

    // R6 row / bank sequence over 12 steps
    do_reset(1'b1, 1'b0);
    while (mux_seen < 12 && !timeout) advance(0);
    for (int k = 1; k <= 12; k++) begin
      int er, eb;
      er = k % 5;
      eb = (k / 5) % 2;
      check(row_log[k] == er && bank_log[k] == eb, "R6", row_log[k] * 10 + bank_log[k], er * 10 + eb);
    end

    // R7 blink timing; R9 ext toggling ignored (peer sees static ext)
    do_reset(1'b1, 1'b0);
    @(negedge clk);
    check(blink == 1'b0, "R7", blink, 0);
    while (blink_rises < 2 && !timeout) advance(0);
    check(first_blink == 64 * 224, "R7", first_blink, 64 * 224);
    check(blink_gap == 128 * 224, "R7", blink_gap, 128 * 224);
    check(lock_err == 0, "R9", lock_err, 0);

    if (timeout) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule